// File: doc/BRIEF.md
# Set-Clear-Toggle Register Bank

A bank of 32-bit control registers behind a simple memory-mapped slave port. Each register occupies a 16-byte slot. The two address bits just above the word offset choose how a write acts on the stored word. It can overwrite the word, OR the data into it, clear the bits that are set in the data, or invert the bits that are set in the data. Software can therefore change single control bits without a read-modify-write sequence, and two agents that own different bits of one register cannot undo each other's changes.

The port has separate read and write address lines, so a read and a write can occur in the same cycle. Read data is registered: it appears the cycle after the read strobe and holds until the next read. An access that is not word aligned, or that targets a slot past the last register, raises a one-cycle error pulse and changes nothing. The number of registers and each register's reset value are parameters.

Top module: `sct_reg_bank`

## Requirements
- R1: The register slot is address bits [ADDR_W-1:4], so registers are 16 bytes apart. A legal write with address bits [3:2] = 2'b00 (offset 0x0) replaces the register with the write data.
- R2: A legal write with address bits [3:2] = 2'b01 (offset 0x4) ORs the write data into the register.
- R3: A legal write with address bits [3:2] = 2'b10 (offset 0x8) clears each register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A legal write with address bits [3:2] = 2'b11 (offset 0xC) inverts each register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A legal read from any of the four offsets of a slot returns that slot's stored value on rd_data_o in the cycle after rd_en_i. rd_data_o holds its value in cycles with no read.
- R6: An access is illegal when address bits [1:0] are not zero or when the slot is NUM_REGS or above. For such an access, err_o is 1 in the next cycle for one cycle, no register changes, and an illegal read returns zero.
- R7: While rst_ni is low, register i takes RST_VALS[32*i+31:32*i] (zero by default), and rd_data_o and err_o are 0.
- R8: When a read and a legal write target the same slot in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write byte address: slot in [ADDR_W-1:4], operation in [3:2] |
| wr_data_i | input | DATA_W | Write data or bit mask |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle pulse for an illegal access |

## Verification
A read and a write can fall in the same cycle. The case that matters is when both target the same slot, with the write using any of the four operations. The bench produces this with directed cycles and with random cycles that pick the read slot equal to the write slot. Each result is compared with a reference array that is updated only after the read value has been taken from it, so the expected read is always the value from before the write.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLR   = 2'b10,
    OP_TOG   = 2'b11
  } sct_op_e;

  function automatic logic [31:0] sct_apply(sct_op_e op, logic [31:0] cur, logic [31:0] d);
    case (op)
      OP_WRITE: sct_apply = d;
      OP_SET:   sct_apply = cur | d;
      OP_CLR:   sct_apply = cur & ~d;
      default:  sct_apply = cur ^ d;
    endcase
  endfunction
endpackage

// File: rtl/sct_addr_decode.sv
module sct_addr_decode #(
  parameter int SLOT_W   = 8,
  parameter int NUM_REGS = 8
) (
  input  logic [SLOT_W-1:0] slot_bits_i,
  input  logic [1:0]        align_bits_i,
  output logic              legal_o
);
  // slot must exist and access must be word aligned
  assign legal_o = (align_bits_i == 2'b00) && (32'(slot_bits_i) < NUM_REGS);
endmodule

// File: rtl/sct_reg_word.sv
module sct_reg_word
  import sct_pkg::*;
#(
  parameter logic [31:0] RST_VAL = '0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  sct_op_e     op_i,
  input  logic [31:0] data_i,
  output logic [31:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= sct_apply(op_i, q_o, data_i);
  end
endmodule

// File: rtl/sct_reg_bank.sv
module sct_reg_bank
  import sct_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VALS = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic              wr_ok, rd_ok;
  sct_op_e           wr_op;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_rd_alias;

  assign wr_slot = wr_addr_i[ADDR_W-1:4];
  assign rd_slot = rd_addr_i[ADDR_W-1:4];
  assign wr_op   = sct_op_e'(wr_addr_i[3:2]);
  // read ignores the operation alias
  assign unused_rd_alias = ^rd_addr_i[3:2];

  sct_addr_decode #(.SLOT_W(SLOT_W), .NUM_REGS(NUM_REGS)) u_wr_dec (
    .slot_bits_i(wr_slot), .align_bits_i(wr_addr_i[1:0]), .legal_o(wr_ok));
  sct_addr_decode #(.SLOT_W(SLOT_W), .NUM_REGS(NUM_REGS)) u_rd_dec (
    .slot_bits_i(rd_slot), .align_bits_i(rd_addr_i[1:0]), .legal_o(rd_ok));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    sct_reg_word #(.RST_VAL(RST_VALS[i*DATA_W +: DATA_W])) u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en_i && wr_ok && (wr_slot == SLOT_W'(i))),
      .op_i   (wr_op),
      .data_i (wr_data_i),
      .q_o    (reg_q[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_ok && rd_slot == SLOT_W'(i)) rd_mux = reg_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      err_o     <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_mux;
      err_o <= (wr_en_i && !wr_ok) || (rd_en_i && !rd_ok);
    end
  end

  // R2
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ok && wr_op == OP_SET) |=>
      ((reg_q[$past(wr_slot)] & $past(wr_data_i)) == $past(wr_data_i)));
  // R3
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ok && wr_op == OP_CLR) |=>
      ((reg_q[$past(wr_slot)] & $past(wr_data_i)) == '0));
  // R4
  tog_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ok && wr_op == OP_TOG) |=>
      ((reg_q[$past(wr_slot)] ^ $past(reg_q[wr_slot])) == $past(wr_data_i)));
  // R6
  ill_wr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ok) |=> err_o);
  // R6
  ill_wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ok) |=> $stable(reg_q));
  // R6
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i || rd_en_i));
  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/sct_reg_bank_bench.sv
module sct_reg_bank_bench;
  localparam int NR = 6;
  localparam int AW = 8;

  function automatic logic [31:0] rst_val(int i);
    return 32'hC3A5_0000 | (i << 8) | (i * 3);
  endfunction
  function automatic logic [NR*32-1:0] build_rv();
    logic [NR*32-1:0] v;
    for (int i = 0; i < NR; i++) v[i*32 +: 32] = rst_val(i);
    return v;
  endfunction
  localparam logic [NR*32-1:0] RV = build_rv();

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic err;
  int checks = 0, errors = 0;
  logic [31:0] mdl [NR];
  logic [31:0] exp_rd = '0;

  always #5 clk = ~clk;

  sct_reg_bank #(.NUM_REGS(NR), .DATA_W(32), .ADDR_W(AW), .RST_VALS(RV)) u_sct_reg_bank (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .err_o(err));

  function automatic logic [31:0] ref_op(logic [1:0] op, logic [31:0] c, logic [31:0] d);
    case (op)
      2'd0: return d;
      2'd1: return c | d;
      2'd2: return c & ~d;
      default: return c ^ d;
    endcase
  endfunction
  function automatic bit legal(logic [AW-1:0] a);
    return a[1:0] == 2'b00 && int'(a[AW-1:4]) < NR;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // drive at negedge, DUT acts at posedge, check at next negedge
  task automatic cyc(bit we, logic [AW-1:0] wa, logic [31:0] wd,
                     bit re, logic [AW-1:0] ra, string tag);
    bit exp_err;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    if (re) exp_rd = legal(ra) ? mdl[ra[AW-1:4]] : 32'h0;
    exp_err = (we && !legal(wa)) || (re && !legal(ra));
    @(negedge clk);
    chk(rd_data === exp_rd, tag, rd_data, exp_rd);
    chk(err === exp_err, {tag, "/R6 err"}, 32'(err), 32'(exp_err));
    if (we && legal(wa)) mdl[wa[AW-1:4]] = ref_op(wa[3:2], mdl[wa[AW-1:4]], wd);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    cyc(0, '0, '0, 1, a, tag);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NR; i++) mdl[i] = rst_val(i);
    repeat (3) @(negedge clk);
    chk(rd_data === 32'h0, "R7 rd_data reset", rd_data, 32'h0);
    chk(err === 1'b0, "R7 err reset", 32'(err), 32'h0);
    rst_ni = 1;
    @(negedge clk);
    // R7 reset values, R5 through every alias
    for (int i = 0; i < NR; i++)
      for (int k = 0; k < 4; k++) rd(AW'(i * 16 + k * 4), "R7/R5 reset value alias");
    // R5 hold without read
    cyc(0, '0, '0, 0, '0, "R5 hold");
    // R1 plain write slot 0, then check slot 1 untouched
    cyc(1, 8'h00, 32'hDEAD_BEEF, 0, '0, "R1 write");
    rd(8'h00, "R1 readback");
    rd(8'h10, "R1 neighbour");
    // R2 set
    cyc(1, 8'h14, 32'h0000_F00F, 0, '0, "R2 set");
    rd(8'h1C, "R2 readback");
    // R3 clear
    cyc(1, 8'h28, 32'hFFFF_0000, 0, '0, "R3 clear");
    rd(8'h20, "R3 readback");
    // R4 toggle twice
    cyc(1, 8'h3C, 32'h0F0F_0F0F, 0, '0, "R4 toggle");
    rd(8'h34, "R4 readback");
    cyc(1, 8'h3C, 32'h0F0F_0F0F, 0, '0, "R4 toggle back");
    rd(8'h38, "R4 restored");
    // R8 same-slot read and write, each op
    for (int k = 0; k < 4; k++) begin
      cyc(1, AW'(8'h40 + k * 4), 32'h1234_5678 << k, 1, 8'h40, "R8 same slot");
      rd(8'h44, "R8 after");
    end
    // R6 misaligned write, out-of-range write, illegal reads
    cyc(1, 8'h02, 32'hFFFF_FFFF, 0, '0, "R6 misaligned write");
    rd(8'h00, "R6 unchanged");
    cyc(1, 8'h60, 32'hFFFF_FFFF, 0, '0, "R6 slot out of range");
    cyc(1, 8'hF4, 32'hFFFF_FFFF, 0, '0, "R6 slot max");
    rd(8'h51, "R6 misaligned read zero");
    rd(8'h70, "R6 out-of-range read zero");
    cyc(0, '0, '0, 0, '0, "R6 err one cycle");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wa, ra;
      bit we, re;
      wa = AW'((($urandom % 8) * 16) | (($urandom % 4) * 4));
      ra = AW'((($urandom % 8) * 16) | (($urandom % 4) * 4));
      if ($urandom % 10 == 0) wa[1:0] = 2'($urandom % 3 + 1);
      if ($urandom % 10 == 0) ra[1:0] = 2'($urandom % 3 + 1);
      if ($urandom % 4 == 0) ra[AW-1:4] = wa[AW-1:4];
      we = ($urandom % 3) != 0;
      re = ($urandom % 3) != 0;
      cyc(we, wa, $urandom, re, ra, "R1-random R5 R8");
    end
    for (int i = 0; i < NR; i++) rd(AW'(i * 16 + 12), "R5 final readback");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule